// File: doc/BRIEF.md
# Presettable Cascadable Synchronous Counter

A small synchronous up counter with a parallel preset, a clear, two count-enable inputs and a carry output meant for chaining stages. Two compile-time parameters pick the variant: the counting modulus (full binary range, or decade counting from 0 to 9) and the clear style (clear on the next rising clock edge, or clear at once without the clock). One module therefore covers four variants.

Each rising edge applies one action, chosen in strict priority order: clear, then preset from the data bus, then advance by one, then hold. Advancing needs both enables high. The carry output depends on only one of the two enables. It is high when that enable is high and the count sits at its terminal value. Wiring a stage's carry to the next stage's carry-gating enable builds a wider counter with look-ahead and no extra gates. The other enable can then be shared as a common advance control.

Top module: `casc_counter`

## Requirements
- R1: While `load_n` is low and `clr_n` is high, `q` takes the value of `din` on the next rising edge, whatever the levels of `cnt_en` and `carry_en`.
- R2: With ASYNC_CLR=0, a low `clr_n` at a rising edge makes `q` equal 0 after that edge. This takes precedence over a load.
- R3: With ASYNC_CLR=1, `q` becomes 0 as soon as `clr_n` goes low, with no clock edge in between, and stays 0 while `clr_n` is low.
- R4: With `clr_n` and `load_n` high, `q` is unchanged across an edge unless both `cnt_en` and `carry_en` are high at that edge.
- R5: With DECADE=0, an enabled advance adds one modulo 2^W, so 15 goes to 0 in the 4-bit default.
- R6: With DECADE=1, an enabled advance goes from 9 to 0, and any loaded value from 10 to 15 goes to 0 on the next enabled advance.
- R7: `carry_out` is high exactly when `carry_en` is high and `q` equals the terminal value (15 binary, 9 decade). `cnt_en` has no effect on it.
- R8: In two stages where the lower stage's `carry_out` drives the upper stage's `carry_en`, the upper stage advances exactly once per full cycle of the lower stage.
- R9: Changes to `cnt_en` or `carry_en` while the clock is high or low do not cause a count. Only their levels at the rising edge matter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all synchronous actions on the rising edge |
| clr_n | input | 1 | Active-low clear, synchronous or asynchronous by parameter |
| load_n | input | 1 | Active-low parallel preset from `din` |
| cnt_en | input | 1 | Count enable that does not gate the carry |
| carry_en | input | 1 | Count enable that also gates `carry_out` |
| din | input | W | Preset value |
| q | output | W | Current count |
| carry_out | output | 1 | Terminal-count carry for cascading |

## Verification
The assertions check on every cycle that a preset lands one edge later, that a disabled or half-enabled counter holds, that an advance follows the modulus (decade wrap from out-of-range values included), and that the carry is never high without `carry_en` or away from the terminal value. Only the bench scenarios can show the clear behaviour, because the assertions are disabled while clear is low. This includes the immediate zeroing of the asynchronous variant between edges. The same applies to enable glitches inside a clock phase and to the two-stage cascade, where the upper stage must step exactly once per lower-stage cycle.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  // Action applied at the next rising edge, highest priority last in the list
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
#(
  parameter bit SYNC_CLR = 1'b1
) (
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    cnt_en,
  input  logic    carry_en,
  output cnt_op_e op
);
  // Priority: clear, load, count, hold
  always_comb begin
    op = OP_HOLD;
    if (SYNC_CLR && !clr_n) begin
      op = OP_CLEAR;
    end else if (!load_n) begin
      op = OP_LOAD;
    end else if (cnt_en && carry_en) begin
      op = OP_COUNT;
    end
  end
endmodule

// File: rtl/cnt_step.sv
module cnt_step
  import cnt_pkg::*;
#(
  parameter int W       = 4,
  parameter int MODULUS = 16
) (
  input  logic [W-1:0] q,
  input  logic [W-1:0] din,
  input  cnt_op_e      op,
  output logic [W-1:0] q_nxt
);
  localparam logic [W-1:0] TERM = W'(MODULUS - 1);
  localparam bit FULL_RANGE = (MODULUS == (1 << W));

  logic [W-1:0] q_inc;

  generate
    if (FULL_RANGE) begin : g_bin
      assign q_inc = q + 1'b1;
    end else begin : g_mod
      // Any value at or past the terminal wraps to zero
      assign q_inc = (q >= TERM) ? '0 : q + 1'b1;
    end
  endgenerate

  always_comb begin
    q_nxt = q;
    case (op)
      OP_CLEAR: q_nxt = '0;
      OP_LOAD:  q_nxt = din;
      OP_COUNT: q_nxt = q_inc;
      default:  q_nxt = q;
    endcase
  end
endmodule

// File: rtl/cnt_carry.sv
module cnt_carry #(
  parameter int W       = 4,
  parameter int MODULUS = 16
) (
  input  logic [W-1:0] q,
  input  logic         carry_en,
  output logic         carry_out
);
  localparam logic [W-1:0] TERM = W'(MODULUS - 1);

  logic at_term;

  assign at_term   = (q == TERM);
  assign carry_out = carry_en & at_term;
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import cnt_pkg::*;
#(
  parameter int W         = 4,
  parameter bit DECADE    = 1'b0,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         cnt_en,
  input  logic         carry_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         carry_out
);
  localparam int MODULUS = DECADE ? 10 : (1 << W);

  cnt_op_e      op;
  logic [W-1:0] q_nxt;
  logic [W-1:0] q_r;

  cnt_ctrl #(.SYNC_CLR(!ASYNC_CLR)) u_ctrl (
    .clr_n    (clr_n),
    .load_n   (load_n),
    .cnt_en   (cnt_en),
    .carry_en (carry_en),
    .op       (op)
  );

  cnt_step #(.W(W), .MODULUS(MODULUS)) u_step (
    .q     (q_r),
    .din   (din),
    .op    (op),
    .q_nxt (q_nxt)
  );

  generate
    if (ASYNC_CLR) begin : g_aclr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
          q_r <= '0;
        end else if (op != OP_HOLD) begin
          q_r <= q_nxt;
        end
      end
    end else begin : g_sclr
      always_ff @(posedge clk) begin
        if (op != OP_HOLD) begin
          q_r <= q_nxt;
        end
      end
    end
  endgenerate

  cnt_carry #(.W(W), .MODULUS(MODULUS)) u_carry (
    .q         (q_r),
    .carry_en  (carry_en),
    .carry_out (carry_out)
  );

  assign q = q_r;
endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
  parameter int W         = 4,
  parameter bit DECADE    = 1'b0,
  parameter bit ASYNC_CLR = 1'b0
) (
  input logic         clk,
  input logic         clr_n,
  input logic         load_n,
  input logic         cnt_en,
  input logic         carry_en,
  input logic [W-1:0] din,
  input logic [W-1:0] q,
  input logic         carry_out
);
  localparam int MOD = DECADE ? 10 : (1 << W);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  // R1: preset lands one edge later
  a_r1_load_lands: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> (q == $past(din)));

  // R4: no advance without both enables
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(cnt_en && carry_en)) |=> $stable(q));

  // R5 / R6: advance follows the modulus
  a_r5_r6_advance: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_en && carry_en) |=>
      (q == (($past(q) >= LAST) ? '0 : $past(q) + 1'b1)));

  // R7: carry needs the gating enable
  a_r7_carry_gated: assert property (@(posedge clk) disable iff (!clr_n)
    !carry_en |-> !carry_out);

  // R7: carry only at the terminal value
  a_r7_carry_term: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out |-> (q == LAST));
endmodule

bind casc_counter casc_counter_chk #(
  .W(W), .DECADE(DECADE), .ASYNC_CLR(ASYNC_CLR)
) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .load_n    (load_n),
  .cnt_en    (cnt_en),
  .carry_en  (carry_en),
  .din       (din),
  .q         (q),
  .carry_out (carry_out)
);

// File: tb/sim_casc_counter.sv
`timescale 1ns/1ps
module sim_casc_counter;
  logic clk;
  logic clr_n, ld_n, p, t;
  logic [3:0] din;
  logic clr2_n, ld2_n, p2, t2;
  logic [3:0] din2;
  logic [3:0] q0, q1, q2;
  logic co0, co1, co2;

  int total = 0;
  int bad = 0;
  int m0 = 0, m1 = 0, m2 = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // lower binary stage, synchronous clear
  casc_counter #(.W(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u0 (
    .clk(clk), .clr_n(clr_n), .load_n(ld_n), .cnt_en(p), .carry_en(t),
    .din(din), .q(q0), .carry_out(co0));
  // upper binary stage, carry-chained
  casc_counter #(.W(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u1 (
    .clk(clk), .clr_n(clr_n), .load_n(ld_n), .cnt_en(p), .carry_en(co0),
    .din(din), .q(q1), .carry_out(co1));
  // standalone decade stage, asynchronous clear
  casc_counter #(.W(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) u2 (
    .clk(clk), .clr_n(clr2_n), .load_n(ld2_n), .cnt_en(p2), .carry_en(t2),
    .din(din2), .q(q2), .carry_out(co2));

  // Behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    bit c0;
    c0 = t && (m0 == 15);
    if (!clr_n) begin
      m0 = 0; m1 = 0;
    end else if (!ld_n) begin
      m0 = din; m1 = din;
    end else begin
      if (p && t)  m0 = (m0 + 1) % 16;
      if (p && c0) m1 = (m1 + 1) % 16;
    end
    if (!clr2_n)      m2 = 0;
    else if (!ld2_n)  m2 = din2;
    else if (p2 && t2) m2 = (m2 >= 9) ? 0 : m2 + 1;
  end
  always @(negedge clr2_n) m2 = 0;

  task automatic chk(input string tag, input string what, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    bit e0;
    e0 = t && (m0 == 15);
    chk(tag, "q0", int'(q0), m0);
    chk(tag, "co0", int'(co0), int'(e0));
    chk(tag, "q1", int'(q1), m1);
    chk(tag, "co1", int'(co1), int'(e0 && (m1 == 15)));
    chk(tag, "q2", int'(q2), m2);
    chk(tag, "co2", int'(co2), int'(t2 && (m2 == 9)));
  endtask

  task automatic step(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare(tag);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clr_n = 0; ld_n = 1; p = 0; t = 0; din = 0;
    clr2_n = 0; ld2_n = 1; p2 = 0; t2 = 0; din2 = 0;
    step("R2", 3);                       // reset state
    chk("R2", "q0 after clear", int'(q0), 0);
    clr_n = 1; clr2_n = 1;
    // binary count with wrap, decade count with wrap
    p = 1; t = 1; p2 = 1; t2 = 1;
    step("R5", 20);
    step("R6", 12);
    // hold with one enable low; carry gating
    p = 0; p2 = 0;
    step("R4", 3);
    p = 1; t = 0; p2 = 1; t2 = 0;
    step("R4", 3);
    // load regardless of enables: 15 with carry enable off
    ld_n = 0; din = 4'd15; p = 0; t = 0;
    ld2_n = 0; din2 = 4'd9; p2 = 0; t2 = 0;
    step("R1", 1);
    chk("R1", "q0 loaded", int'(q0), 15);
    ld_n = 1; ld2_n = 1;
    step("R7", 2);                       // carry off with T low
    t = 1; p = 0; t2 = 1; p2 = 0;
    step("R7", 2);                       // carry on with P low
    chk("R7", "co0 with P low", int'(co0), 1);
    // decade: out-of-range load goes to 0 on next advance
    ld2_n = 0; din2 = 4'd12;
    step("R6", 1);
    ld2_n = 1; p2 = 1;
    step("R6", 1);
    chk("R6", "q2 from 12", int'(q2), 0);
    // synchronous clear beats load
    clr_n = 0; ld_n = 0; din = 4'd7;
    step("R2", 1);
    chk("R2", "q0 clear over load", int'(q0), 0);
    ld_n = 1; clr_n = 1;
    // asynchronous clear between edges
    @(negedge clk);
    #0.5 clr2_n = 0;
    #0.5;
    chk("R3", "q2 immediate clear", int'(q2), 0);
    step("R3", 2);
    clr2_n = 1;
    // cascade: 48 lower-stage advances -> upper steps 3 times
    p = 1; t = 1;
    step("R8", 48);
    chk("R8", "upper after 3 cycles", int'(q1), 3);
    chk("R8", "lower after 3 cycles", int'(q0), 0);
    // enable glitches inside clock phases
    p = 0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      #0.5 p = 1;
      #0.5 p = 0;
      @(negedge clk);
      compare("R9");
      p = 1;
      #0.5 p = 0;
    end
    chk("R9", "q0 unchanged by glitches", int'(q0), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule